// File: doc/BRIEF.md
# Quarter-Strip Cluster Centroid Divider

This block converts one strip cluster, given as a charge-weighted position sum (numerator) and a total charge (denominator), into the absolute position of the cluster's centre of gravity in units of a quarter strip. It avoids an iterative divider. The denominator is normalized so that its six leading bits, together with the equally shifted excess of the numerator over the denominator, select an entry of a quotient table. That table is computed from its own index inside the design. The table returns a small rounded quarter-strip code, which is then added to the seed (first strip) address.

The numerator weights each strip's charge by its position counted from 1 at the seed strip. The ratio numerator/denominator therefore lies between 1 and the maximum cluster size, and the excess ratio (numerator − denominator)/denominator is the offset of the centroid from the seed. Records enter through a valid/ready handshake that accepts at most one record every two clocks. Each result appears on a one-cycle output strobe a fixed number of cycles later. Clusters marked oversize, and clusters with zero charge, come out flagged with a zeroed position.

Top module: `qcent_div`

## Requirements
- R1: While reset is asserted and after it is released with no input, `inReady` is 1 and `outValid` is 0.
- R2: A record is accepted on a rising edge where `inValid` and `inReady` are both 1; `inReady` is 0 for the one cycle after that edge and 1 again in the next.
- R3: A record accepted at the end of cycle t gives `outValid` = 1 in cycle t+3 and only then, so each accepted record gives exactly one one-cycle output pulse, in order of acceptance.
- R4: For a denominator D below 64 with numerator N in [D, 5D], the quarter-strip offset c = `outCentroid` − 4·`inSeed` equals floor((8·(N−D) + D) / (2·D)), i.e. 4·(N−D)/D rounded to nearest with ties upward.
- R5: For a denominator of 64 or more (up to 5·255) with N in [D, 5D], only the six leading bits of D and the same-shifted excess N−D are used, and the offset c satisfies |c·D − 4·(N−D)| ≤ D (within one quarter strip of the exact value).
- R6: `outCentroid` is an unsigned strip number with the two least significant bits as the quarter-strip fraction, equal to 4·seed + c, with no overflow for seed 511 and c = 16.
- R7: A zero denominator gives `outBad` = 1 and `outCentroid` = 0.
- R8: `inOversize` = 1 gives `outBad` = 1 and `outCentroid` = 0 whatever the numerator and denominator are.
- R9: A numerator below the denominator is treated as zero offset: `outCentroid` = 4·seed and `outBad` = 0.
- R10: The offset saturates at 16 quarter strips, so with D below 64 and N above 5D the output is 4·seed + 16.
- R11: Data presented with `inValid` = 1 while `inReady` = 0 is ignored; no output is produced for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input record present |
| inReady | output | 1 | Block can accept a record at the next edge |
| inNum | input | 13 | Position-weighted charge sum (positions counted from 1) |
| inDen | input | 11 | Total cluster charge |
| inSeed | input | 9 | Strip address of the first strip of the cluster |
| inOversize | input | 1 | Cluster exceeded the maximum size; forces a flagged result |
| outValid | output | 1 | One-cycle strobe: result fields are valid |
| outCentroid | output | 12 | Absolute centroid, strip number with 2 fractional bits |
| outBad | output | 1 | Result is invalid (oversize or zero charge) |

## Verification
Every small denominator from 1 to 63 is swept against numerators that cover the full offset range. Because no normalization happens there, these records expose any rounding or tie error exactly. Large denominators up to the full five-strip charge are stepped over forty evenly spaced offsets each, which shows whether the shared shift and the midpoint correction keep the truncated lookup within a quarter strip. Charge profiles built from real one- to five-strip clusters, seeds at both address extremes, zero charge, oversize, numerators below the denominator and above five times it separate the flagging, clamping and seed-addition paths. A record changed during the not-ready cycle shows whether the handshake ignores it.

// File: rtl/qcent_pkg.sv
package qcent_pkg;

  // control-to-datapath load strobes, one per pipeline stage
  typedef struct packed {
    logic ldIn;
    logic ldLut;
    logic ldOut;
  } qcStrobe_t;

  // Table entry generator: rounded quotient in 1/quant units.
  // With midPt set, both indices stand for truncated values, so the
  // middle of each truncation interval is used instead of its floor.
  function automatic int unsigned quarterCode(int unsigned eIdx, int unsigned dIdx,
                                              logic midPt, int unsigned quant,
                                              int unsigned maxCode);
    int unsigned numV;
    int unsigned denV;
    int unsigned codeV;
    if (midPt) begin
      numV = quant * (2 * eIdx + 1);
      denV = 2 * dIdx + 1;
    end else begin
      numV = quant * eIdx;
      denV = dIdx;
    end
    if (denV == 0) codeV = 0;
    else           codeV = (2 * numV + denV) / (2 * denV);
    if (codeV > maxCode) codeV = maxCode;
    return codeV;
  endfunction

endpackage

// File: rtl/qcent_ctrl.sv
module qcent_ctrl
  import qcent_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output logic      inReady,
  output logic      outValid,
  output qcStrobe_t stb
);

  logic accept;
  logic stage1Busy;
  logic stage2Busy;
  logic stage3Busy;

  assign accept = inValid && inReady;

  // the cycle after an acceptance is spent in the first stage, so the
  // input is closed for exactly that cycle
  assign inReady = !stage1Busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Busy <= 1'b0;
      stage2Busy <= 1'b0;
      stage3Busy <= 1'b0;
    end else begin
      stage1Busy <= accept;
      stage2Busy <= stage1Busy;
      stage3Busy <= stage2Busy;
    end
  end

  assign outValid = stage3Busy;

  always_comb begin
    stb.ldIn  = accept;
    stb.ldLut = stage1Busy;
    stb.ldOut = stage2Busy;
  end

  // R2
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> ##3 outValid);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

endmodule

// File: rtl/qcent_dpath.sv
module qcent_dpath
  import qcent_pkg::*;
#(
  parameter int NUM_W     = 13,
  parameter int DEN_W     = 11,
  parameter int ADDR_W    = 9,
  parameter int DEN_IDX_W = 6,
  parameter int EXC_IDX_W = 8,
  parameter int FRAC_W    = 2,
  parameter int MAX_CODE  = 16,
  parameter int CODE_W    = 5,
  parameter int OUT_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  qcStrobe_t         stb,
  input  logic [NUM_W-1:0]  inNum,
  input  logic [DEN_W-1:0]  inDen,
  input  logic [ADDR_W-1:0] inSeed,
  input  logic              inOver,
  output logic [OUT_W-1:0]  centOut,
  output logic              badOut
);

  localparam int SH_W    = $clog2(DEN_W);
  localparam int QUANT   = 1 << FRAC_W;
  localparam int EXC_MAX = (1 << EXC_IDX_W) - 1;

  // ---------------- stage 1: capture ----------------
  logic [NUM_W-1:0]  s1Num;
  logic [DEN_W-1:0]  s1Den;
  logic [ADDR_W-1:0] s1Seed;
  logic              s1Bad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Num  <= '0;
      s1Den  <= '0;
      s1Seed <= '0;
      s1Bad  <= 1'b0;
    end else if (stb.ldIn) begin
      s1Num  <= inNum;
      s1Den  <= inDen;
      s1Seed <= inSeed;
      s1Bad  <= inOver || (inDen == '0);
    end
  end

  // ---------------- stage 2: normalize and look up ----------------
  logic [SH_W-1:0]      msbPos;
  logic [SH_W-1:0]      shAmt;
  logic [NUM_W-1:0]     excess;
  logic [NUM_W-1:0]     excShift;
  logic [DEN_W-1:0]     denShift;
  logic [EXC_IDX_W-1:0] eIdx;
  logic [DEN_IDX_W-1:0] dIdx;
  logic                 midPt;
  logic [CODE_W-1:0]    lutCode;

  always_comb begin
    msbPos = '0;
    for (int i = 0; i < DEN_W; i++) begin
      if (s1Den[i]) msbPos = SH_W'(i);
    end
  end

  always_comb begin
    if (int'(msbPos) >= DEN_IDX_W) shAmt = SH_W'(int'(msbPos) - (DEN_IDX_W - 1));
    else                           shAmt = '0;
  end

  always_comb begin
    if (s1Num >= NUM_W'(s1Den)) excess = s1Num - NUM_W'(s1Den);
    else                        excess = '0;
    excShift = excess >> shAmt;
    denShift = s1Den >> shAmt;
    if (excShift > NUM_W'(EXC_MAX)) eIdx = EXC_IDX_W'(EXC_MAX);
    else                            eIdx = excShift[EXC_IDX_W-1:0];
    dIdx    = denShift[DEN_IDX_W-1:0];
    midPt   = (shAmt != '0);
    lutCode = CODE_W'(quarterCode(int'(eIdx), int'(dIdx), midPt, QUANT, MAX_CODE));
  end

  logic [CODE_W-1:0] s2Code;
  logic [ADDR_W-1:0] s2Seed;
  logic              s2Bad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Code <= '0;
      s2Seed <= '0;
      s2Bad  <= 1'b0;
    end else if (stb.ldLut) begin
      s2Code <= lutCode;
      s2Seed <= s1Seed;
      s2Bad  <= s1Bad;
    end
  end

  // ---------------- stage 3: absolute position ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      centOut <= '0;
      badOut  <= 1'b0;
    end else if (stb.ldOut) begin
      centOut <= s2Bad ? '0 : ({1'b0, s2Seed, FRAC_W'(0)} + OUT_W'(s2Code));
      badOut  <= s2Bad;
    end
  end

  // R7 R8
  bad_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldIn && (inOver || inDen == '0)) |-> ##3 (badOut && centOut == '0));

  // R6
  seed_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldIn && !inOver && inDen != '0) |-> ##3
      (!badOut && centOut >= OUT_W'({$past(inSeed, 3), FRAC_W'(0)})));

  // R10
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldOut && !s2Bad) |=>
      (centOut <= OUT_W'({$past(s2Seed), FRAC_W'(0)}) + OUT_W'(MAX_CODE)));

endmodule

// File: rtl/qcent_div.sv
module qcent_div
  import qcent_pkg::*;
#(
  parameter int ADC_W      = 8,
  parameter int MAX_STRIPS = 5,
  parameter int ADDR_W     = 9,
  parameter int DEN_IDX_W  = 6,
  parameter int FRAC_W     = 2,
  localparam int DEN_W     = $clog2(MAX_STRIPS * ((1 << ADC_W) - 1) + 1),
  localparam int NUM_W     = $clog2(MAX_STRIPS * MAX_STRIPS * ((1 << ADC_W) - 1) + 1),
  localparam int OUT_W     = ADDR_W + 1 + FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [NUM_W-1:0]  inNum,
  input  logic [DEN_W-1:0]  inDen,
  input  logic [ADDR_W-1:0] inSeed,
  input  logic              inOversize,
  output logic              outValid,
  output logic [OUT_W-1:0]  outCentroid,
  output logic              outBad
);

  localparam int EXC_IDX_W = DEN_IDX_W + $clog2(MAX_STRIPS - 1);
  localparam int MAX_CODE  = (MAX_STRIPS - 1) << FRAC_W;
  localparam int CODE_W    = $clog2(MAX_CODE + 1);

  qcStrobe_t stb;

  qcent_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .stb      (stb)
  );

  qcent_dpath #(
    .NUM_W     (NUM_W),
    .DEN_W     (DEN_W),
    .ADDR_W    (ADDR_W),
    .DEN_IDX_W (DEN_IDX_W),
    .EXC_IDX_W (EXC_IDX_W),
    .FRAC_W    (FRAC_W),
    .MAX_CODE  (MAX_CODE),
    .CODE_W    (CODE_W),
    .OUT_W     (OUT_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inNum   (inNum),
    .inDen   (inDen),
    .inSeed  (inSeed),
    .inOver  (inOversize),
    .centOut (outCentroid),
    .badOut  (outBad)
  );

endmodule

// File: tb/qcent_div_tb.sv
`timescale 1ns/1ps
module qcent_div_tb;

  localparam int NW = 13;
  localparam int DW = 11;
  localparam int AW = 9;
  localparam int OW = 12;

  logic          clk = 1'b0;
  logic          rstN;
  logic          inValid;
  logic          inReady;
  logic [NW-1:0] inNum;
  logic [DW-1:0] inDen;
  logic [AW-1:0] inSeed;
  logic          inOversize;
  logic          outValid;
  logic [OW-1:0] outCentroid;
  logic          outBad;

  always #4 clk = ~clk;

  qcent_div u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inReady     (inReady),
    .inNum       (inNum),
    .inDen       (inDen),
    .inSeed      (inSeed),
    .inOversize  (inOversize),
    .outValid    (outValid),
    .outCentroid (outCentroid),
    .outBad      (outBad)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int pushCount = 0;
  int outCount = 0;
  bit done = 1'b0;

  int qN[$];
  int qD[$];
  int qSeed[$];
  int qOver[$];
  int qCyc[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // output monitor and scoreboard
  always @(negedge clk) begin : monitor
    int n, d, s, ov, acc, c, e, expC, err;
    string lab;
    if (rstN === 1'b1 && outValid === 1'b1) begin
      outCount++;
      if (qN.size() == 0) begin
        chk(1'b0, "R11", "output without accepted record", outCount, pushCount);
      end else begin
        n = qN.pop_front();   d = qD.pop_front();  s = qSeed.pop_front();
        ov = qOver.pop_front(); acc = qCyc.pop_front();
        chk(cyc == acc + 3, "R3", "result cycle", cyc, acc + 3);
        if (ov != 0 || d == 0) begin
          lab = (ov != 0) ? "R8" : "R7";
          chk(outBad == 1'b1, lab, "bad flag", int'(outBad), 1);
          chk(outCentroid == '0, lab, "flagged centroid", int'(outCentroid), 0);
        end else begin
          chk(outBad == 1'b0, "R6", "bad flag on good record", int'(outBad), 0);
          c = int'(outCentroid) - 4 * s;
          if (n < d) begin
            chk(c == 0, "R9", "offset for numerator below denominator", c, 0);
          end else if (d < 64) begin
            e = n - d;
            expC = (8 * e + d) / (2 * d);
            if (expC > 16) expC = 16;
            if (e > 4 * d)               lab = "R10";
            else if (s == 0 || s == 511) lab = "R6";
            else                         lab = "R4";
            chk(c == expC, lab, "exact offset", c, expC);
          end else begin
            e = n - d;
            err = c * d - 4 * e;
            if (err < 0) err = -err;
            chk(c >= 0 && c <= 16 && err <= d, "R5", "offset within a quarter strip",
                c, (4 * e + d / 2) / d);
          end
        end
      end
    end
  end

  task automatic push(int n, int d, int s, bit ov);
    qN.push_back(n); qD.push_back(d); qSeed.push_back(s);
    qOver.push_back(int'(ov)); qCyc.push_back(cyc);
    pushCount++;
  endtask

  task automatic send(int n, int d, int s, bit ov);
    @(negedge clk);
    inNum = NW'(n); inDen = DW'(d); inSeed = AW'(s); inOversize = ov;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    push(n, d, s, ov);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // record changed while not ready must vanish
  task automatic ignoreCheck();
    @(negedge clk);
    inNum = 13'd60; inDen = 11'd20; inSeed = 9'd10; inOversize = 1'b0; inValid = 1'b1;
    chk(inReady == 1'b1, "R2", "ready before record", int'(inReady), 1);
    push(60, 20, 10, 1'b0);
    @(negedge clk);
    inNum = 13'd100; inDen = 11'd20; inSeed = 9'd200; inOversize = 1'b0;
    chk(inReady == 1'b0, "R2", "ready in cycle after accept", int'(inReady), 0);
    @(negedge clk);
    inNum = 13'd45; inDen = 11'd30; inSeed = 9'd300; inOversize = 1'b0;
    chk(inReady == 1'b1, "R2", "ready two cycles after accept", int'(inReady), 1);
    push(45, 30, 300, 1'b0);
    @(negedge clk);
    inValid = 1'b0;
    repeat (6) @(negedge clk);
    chk(outCount == pushCount, "R11", "outputs after ignored record", outCount, pushCount);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R3 watchdog: actual run unfinished expected done");
      finishRun();
    end
  end

  initial begin : stimulus
    int adc, n, d;
    rstN = 1'b0; inValid = 1'b0; inNum = '0; inDen = '0; inSeed = '0; inOversize = 1'b0;
    repeat (3) @(negedge clk);
    chk(inReady == 1'b1, "R1", "ready in reset", int'(inReady), 1);
    chk(outValid == 1'b0, "R1", "valid in reset", int'(outValid), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(inReady == 1'b1, "R1", "ready after reset", int'(inReady), 1);
    chk(outValid == 1'b0, "R1", "valid after reset", int'(outValid), 0);

    ignoreCheck();

    // small denominators: exact rounding
    for (int dd = 1; dd < 64; dd++) begin
      for (int e = 0; e <= 4 * dd; e += (dd < 16) ? 1 : 3) begin
        send(dd + e, dd, (dd * 7 + e) % 512, 1'b0);
      end
    end
    // seed extremes
    send(5 * 40, 40, 511, 1'b0);
    send(3 * 17, 17, 0, 1'b0);
    send(5 * 63, 63, 511, 1'b0);

    // large denominators: truncated index
    for (int dd = 64; dd <= 1275; dd += 13) begin
      for (int k = 0; k <= 40; k++) begin
        send(dd + (4 * dd * k) / 40, dd, (dd + k) % 512, 1'b0);
      end
    end
    send(1275, 1275, 100, 1'b0);
    send(6375, 1275, 101, 1'b0);
    send(1275 + 2 * 1275, 1275, 102, 1'b0);

    // realistic cluster charge profiles
    for (int sz = 1; sz <= 5; sz++) begin
      for (int p = 0; p < 16; p++) begin
        n = 0; d = 0;
        for (int i = 1; i <= sz; i++) begin
          adc = ((i * 37 + p * 11) % 255) + 1;
          n += i * adc;
          d += adc;
        end
        send(n, d, (p * 31) % 500, 1'b0);
      end
    end

    // flagged records
    send(0, 0, 77, 1'b0);
    send(500, 0, 78, 1'b0);
    send(300, 100, 79, 1'b1);
    send(0, 0, 80, 1'b1);
    // numerator below denominator
    send(10, 50, 81, 1'b0);
    send(0, 900, 82, 1'b0);
    // above five times the denominator
    send(6 * 30, 30, 83, 1'b0);
    send(6 * 63, 63, 511, 1'b0);
    send(8191, 10, 84, 1'b0);

    idle(8);
    chk(qN.size() == 0, "R3", "pending results after drain", qN.size(), 0);
    chk(outCount == pushCount, "R11", "output count", outCount, pushCount);
    finishRun();
  end

endmodule